// File: doc/BRIEF.md
# E1 Transmit Timeslot-0 Framer with CRC-4 Multiframe

This block produces the serial 2048 kbit/s transmit stream, one bit per clock enable-free cycle. It counts bit, timeslot and frame positions itself. It inserts the timeslot-0 overhead and passes a caller-supplied payload bit through for timeslots 1 to 31. Each frame is 256 bits, made of 32 eight-bit slots and sent most significant bit first. Even frames carry the alignment word. Odd frames carry a fixed one, the remote alarm and five national spare bits.

With CRC-4 enabled, sixteen frames form a multiframe, split into two halves of eight frames. Bit 1 of timeslot 0 then carries several things. It carries the multiframe pattern and the two far-end error indications. It also carries four check bits, computed over the previous half as transmitted. A multiframe start strobe lets downstream logic and the user align to the stream. The user presents a new payload bit whenever the request output is high.

Top module: `e1_crc4_framer`

## Requirements
- R1: Frames are 256 bits long and timeslot 0 comes first. When `payload_req_o` is high at a clock edge, the value on `payload_i` at that edge appears on `tx_o` one cycle later. `payload_req_o` is high exactly while the next bit to be produced lies in timeslots 1 to 31.
- R2: In frames 0, 2, ..., 14, bits 2 to 8 of timeslot 0 are 0,0,1,1,0,1,1.
- R3: In odd frames, timeslot 0 carries the following: bit 2 = 1, bit 3 = `alarm_i`, and bits 4 to 8 = `sa_i[4]` down to `sa_i[0]`.
- R4: With `crc_en_i` = 1, bit 1 of timeslot 0 in frames 1, 3, 5, 7, 9 and 11 is 0,0,1,0,1,1.
- R5: With `crc_en_i` = 1, bit 1 of frame 13 is the inverse of `smf_err_i[0]` and bit 1 of frame 15 is the inverse of `smf_err_i[1]`.
- R6: With `crc_en_i` = 1, bit 1 of frames 0,2,4,6 (and of frames 8,10,12,14) carries C1..C4. These are the remainder of x^4 + x + 1 over the previous eight-frame half as sent. The half is taken first bit first and padded with four zeros, with each check-bit position counted as 0. C1 is the most significant bit of the remainder.
- R7: Until one full half has been sent after reset, the check bits are sent as 0.
- R8: With `crc_en_i` = 0, bit 1 of timeslot 0 is 1 in every frame.
- R9: `mf_sync_o` is high exactly while `tx_o` carries bit 1 of frame 0, once every 4096 cycles.
- R10: While reset is asserted, `tx_o`, `mf_sync_o` and `payload_req_o` are 0. The first bit after reset release is bit 1 of frame 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| crc_en_i | input | 1 | Enable the CRC-4 multiframe use of bit 1 |
| alarm_i | input | 1 | Remote alarm bit for odd frames |
| sa_i | input | 5 | National spare bits; bit 4 is sent first |
| smf_err_i | input | 2 | Error flags for the received first and second half |
| payload_i | input | 1 | Payload bit, taken when requested |
| payload_req_o | output | 1 | The payload bit is taken at this edge |
| tx_o | output | 1 | Serial transmit stream |
| mf_sync_o | output | 1 | High with bit 1 of frame 0 on `tx_o` |

## Verification
Each output register is loaded from the position counter at the edge. A bit therefore appears on `tx_o` one cycle after its position is reached. The payload sampled at that same edge shows up one cycle later. `payload_req_o` is combinational and already refers to the next position. The bench drives inputs on the falling edge. At falling edge k it reads bit k of the captured stream, together with the payload value that was present at the preceding rising edge. It compares the request against position k+1. Check bits are due one half-multiframe after the data they cover, so each is checked against a remainder that the bench computes from the captured previous half.

// File: rtl/e1_pkg.sv
package e1_pkg;
  localparam logic [6:0] FAS_WORD = 7'b0011011;
  localparam logic [5:0] MF_WORD  = 6'b001011;
  localparam logic [3:0] CRC_POLY = 4'b0011; // x^4 + x + 1, x^4 implied
endpackage

// File: rtl/e1_pos_cnt.sv
module e1_pos_cnt #(
  parameter int TS_W   = 8,
  parameter int NUM_TS = 32,
  parameter int MF_LEN = 16,
  localparam int BIT_W = $clog2(TS_W),
  localparam int TSI_W = $clog2(NUM_TS),
  localparam int FRM_W = $clog2(MF_LEN)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [BIT_W-1:0] bit_o,
  output logic [TSI_W-1:0] ts_o,
  output logic [FRM_W-1:0] frm_o,
  output logic             half_end_o
);
  localparam logic [BIT_W-1:0] BIT_LAST  = BIT_W'(TS_W - 1);
  localparam logic [TSI_W-1:0] TS_LAST   = TSI_W'(NUM_TS - 1);
  localparam logic [FRM_W-1:0] FRM_LAST  = FRM_W'(MF_LEN - 1);
  localparam logic [FRM_W-2:0] HALF_LAST = {(FRM_W-1){1'b1}};

  logic bit_wrap, ts_wrap;
  assign bit_wrap = (bit_o == BIT_LAST);
  assign ts_wrap  = bit_wrap && (ts_o == TS_LAST);
  assign half_end_o = ts_wrap && (frm_o[FRM_W-2:0] == HALF_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_o <= '0;
      ts_o  <= '0;
      frm_o <= '0;
    end else begin
      bit_o <= bit_wrap ? '0 : bit_o + 1'b1;
      if (bit_wrap) ts_o <= (ts_o == TS_LAST) ? '0 : ts_o + 1'b1;
      if (ts_wrap)  frm_o <= (frm_o == FRM_LAST) ? '0 : frm_o + 1'b1;
    end
  end
endmodule

// File: rtl/e1_crc4.sv
module e1_crc4 #(
  parameter int CRC_W = 4,
  parameter logic [CRC_W-1:0] POLY = e1_pkg::CRC_POLY
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             din_i,
  input  logic             blk_end_i,
  output logic [CRC_W-1:0] crc_o
);
  logic [CRC_W-1:0] acc_q, acc_nxt;
  logic             fb;

  assign fb      = acc_q[CRC_W-1] ^ din_i;
  assign acc_nxt = {acc_q[CRC_W-2:0], 1'b0} ^ ({CRC_W{fb}} & POLY);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      crc_o <= '0;
    end else if (blk_end_i) begin
      acc_q <= '0;
      crc_o <= acc_nxt;
    end else begin
      acc_q <= acc_nxt;
    end
  end
endmodule

// File: rtl/e1_ts0_gen.sv
module e1_ts0_gen
  import e1_pkg::*;
(
  input  logic [3:0] frm_i,
  input  logic [2:0] bit_i,
  input  logic       crc_en_i,
  input  logic       alarm_i,
  input  logic [4:0] sa_i,
  input  logic [1:0] err_i,
  input  logic [3:0] crc_i,
  output logic       ovh_o
);
  logic [7:0] fas8, mf8, sa8;
  logic [2:0] mf_idx;
  logic [1:0] c_idx;
  logic       b1_even, b1_odd;

  assign fas8   = {1'b0, FAS_WORD};
  assign mf8    = {2'b00, MF_WORD};
  assign sa8    = {3'b000, sa_i};
  assign mf_idx = 3'd5 - frm_i[3:1];
  assign c_idx  = ~frm_i[2:1];  // C1 is crc msb

  always_comb begin
    b1_even = crc_en_i ? crc_i[c_idx] : 1'b1;
    if (!crc_en_i)          b1_odd = 1'b1;
    else if (frm_i == 4'd13) b1_odd = ~err_i[0];
    else if (frm_i == 4'd15) b1_odd = ~err_i[1];
    else                    b1_odd = mf8[mf_idx];
  end

  always_comb begin
    if (!frm_i[0]) begin
      ovh_o = (bit_i == 3'd0) ? b1_even : fas8[~bit_i];
    end else begin
      unique case (bit_i)
        3'd0:    ovh_o = b1_odd;
        3'd1:    ovh_o = 1'b1;
        3'd2:    ovh_o = alarm_i;
        default: ovh_o = sa8[~bit_i];
      endcase
    end
  end
endmodule

// File: rtl/e1_crc4_framer.sv
module e1_crc4_framer #(
  parameter int TS_W   = 8,
  parameter int NUM_TS = 32,
  parameter int MF_LEN = 16,
  localparam int BIT_W = $clog2(TS_W),
  localparam int TSI_W = $clog2(NUM_TS),
  localparam int FRM_W = $clog2(MF_LEN),
  localparam int SA_W  = TS_W - 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            crc_en_i,
  input  logic            alarm_i,
  input  logic [SA_W-1:0] sa_i,
  input  logic [1:0]      smf_err_i,
  input  logic            payload_i,
  output logic            payload_req_o,
  output logic            tx_o,
  output logic            mf_sync_o
);
  logic [BIT_W-1:0] bit_idx;
  logic [TSI_W-1:0] ts_idx;
  logic [FRM_W-1:0] frm_idx;
  logic             half_end, ovh_bit, nxt_bit, c_slot, crc_din, mf_start;
  logic [3:0]       c_hold;

  e1_pos_cnt #(.TS_W(TS_W), .NUM_TS(NUM_TS), .MF_LEN(MF_LEN)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .bit_o      (bit_idx),
    .ts_o       (ts_idx),
    .frm_o      (frm_idx),
    .half_end_o (half_end)
  );

  e1_ts0_gen u_ts0 (
    .frm_i    (frm_idx),
    .bit_i    (bit_idx),
    .crc_en_i (crc_en_i),
    .alarm_i  (alarm_i),
    .sa_i     (sa_i),
    .err_i    (smf_err_i),
    .crc_i    (c_hold),
    .ovh_o    (ovh_bit)
  );

  assign payload_req_o = (ts_idx != '0);
  assign nxt_bit       = payload_req_o ? payload_i : ovh_bit;
  assign c_slot        = !payload_req_o && (bit_idx == '0) && !frm_idx[0];
  assign crc_din       = c_slot ? 1'b0 : nxt_bit;
  assign mf_start      = !payload_req_o && (bit_idx == '0) && (frm_idx == '0);

  e1_crc4 u_crc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .din_i     (crc_din),
    .blk_end_i (half_end),
    .crc_o     (c_hold)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_o      <= 1'b0;
      mf_sync_o <= 1'b0;
    end else begin
      tx_o      <= nxt_bit;
      mf_sync_o <= mf_start;
    end
  end
endmodule

// File: rtl/e1_framer_chk.sv
module e1_framer_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic crc_en_i,
  input logic alarm_i,
  input logic payload_req_o,
  input logic tx_o,
  input logic mf_sync_o
);
  localparam logic [6:0] FAS_REF = 7'b0011011;
  logic        st;
  logic [11:0] pos;  // index of the bit now on tx_o

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st  <= 1'b0;
      pos <= '0;
    end else begin
      st <= 1'b1;
      if (st) pos <= pos + 1'b1;
    end
  end

  AST_SYNC_PERIOD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st |-> (mf_sync_o == (pos == 12'd0))); // R9
  AST_NO_REQ_AT_SYNC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mf_sync_o |-> !payload_req_o); // R1
  AST_FAS_WORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st && !pos[8] && pos[7:3] == 5'd0 && pos[2:0] != 3'd0) |-> (tx_o == FAS_REF[~pos[2:0]])); // R2
  AST_ODD_FIXED_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st && pos[8] && pos[7:0] == 8'd1) |-> tx_o); // R3
  AST_ODD_ALARM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st && pos[8] && pos[7:0] == 8'd2) |-> (tx_o == $past(alarm_i))); // R3
  AST_BIT1_WHEN_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st && pos[7:0] == 8'd0 && !$past(crc_en_i)) |-> tx_o); // R8
endmodule

bind e1_crc4_framer e1_framer_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .crc_en_i      (crc_en_i),
  .alarm_i       (alarm_i),
  .payload_req_o (payload_req_o),
  .tx_o          (tx_o),
  .mf_sync_o     (mf_sync_o)
);

// File: tb/sim_e1_crc4_framer.sv
module sim_e1_crc4_framer;
  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic crc_en_i, alarm_i, payload_i;
  logic [4:0] sa_i;
  logic [1:0] smf_err_i;
  logic payload_req_o, tx_o, mf_sync_o;

  e1_crc4_framer u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .crc_en_i(crc_en_i), .alarm_i(alarm_i),
    .sa_i(sa_i), .smf_err_i(smf_err_i), .payload_i(payload_i),
    .payload_req_o(payload_req_o), .tx_o(tx_o), .mf_sync_o(mf_sync_o)
  );

  always #2 clk_i = ~clk_i;

  localparam logic [6:0] FAS = 7'b0011011;
  localparam logic [5:0] MFP = 6'b001011;
  // {crc_en, alarm, sa[4:0], err[1:0]}
  localparam logic [8:0] VEC [0:4] = '{
    {1'b1, 1'b0, 5'b10110, 2'b00},
    {1'b1, 1'b1, 5'b01001, 2'b01},
    {1'b1, 1'b0, 5'b11111, 2'b10},
    {1'b0, 1'b1, 5'b00000, 2'b11},
    {1'b1, 1'b1, 5'b10101, 2'b11}
  };

  int total = 0, bad = 0;
  logic [15:0] lfsr = 16'hACE1;
  logic cap [0:8191];
  logic epl [0:8191];
  logic rq  [0:8191];
  logic sy  [0:8191];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic step_pl();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    payload_i = lfsr[0];
  endtask

  task automatic grab(input int k);
    cap[k] = tx_o; sy[k] = mf_sync_o; rq[k] = payload_req_o; epl[k] = payload_i;
    step_pl();
  endtask

  task automatic wait_sync(output int waited);
    waited = 0;
    forever begin
      @(negedge clk_i);
      waited++;
      if (mf_sync_o) begin grab(0); break; end
      step_pl();
    end
  endtask

  task automatic capture(input int n);
    for (int k = 1; k < n; k++) begin
      @(negedge clk_i);
      grab(k);
    end
  endtask

  function automatic logic [3:0] ref_crc(input int base);
    logic [4:0] r = '0;
    logic b;
    for (int i = 0; i < 2052; i++) begin
      if (i >= 2048) b = 1'b0;
      else if (i % 256 == 0 && (i / 256) % 2 == 0) b = 1'b0;
      else b = cap[base + i];
      r = {r[3:0], b};
      if (r[4]) r = r ^ 5'b10011;
    end
    return r[3:0];
  endfunction

  task automatic analyze(input int n, input bit en, input bit a, input logic [4:0] sa,
                         input logic [1:0] err, input bit fresh);
    int b_pl = 0, b_rq = 0, b_fas = 0, b_odd = 0, b_mf = 0, b_e = 0, b_c = 0, b_c0 = 0, b_off = 0, b_sy = 0;
    logic [3:0] cr;
    logic e;
    for (int k = 0; k < n; k++) begin
      if (rq[k] !== (((k + 1) % 256) >= 8)) b_rq++;
      if (sy[k] !== (k % 4096 == 0)) b_sy++;
      if ((k % 256) >= 8 && cap[k] !== epl[k]) b_pl++;
    end
    for (int fi = 0; fi < n / 256; fi++) begin
      int f = fi % 16, base = fi * 256, s = fi / 8;
      if (f % 2 == 0) begin
        for (int b = 1; b < 8; b++) if (cap[base + b] !== FAS[7 - b]) b_fas++;
        if (!en) begin
          if (cap[base] !== 1'b1) b_off++;
        end else if (s == 0) begin
          if (fresh && cap[base] !== 1'b0) b_c0++;
        end else begin
          cr = ref_crc((s - 1) * 2048);
          if (cap[base] !== cr[3 - (f % 8) / 2]) b_c++;
        end
      end else begin
        if (cap[base + 1] !== 1'b1) b_odd++;
        if (cap[base + 2] !== a) b_odd++;
        for (int b = 3; b < 8; b++) if (cap[base + b] !== sa[7 - b]) b_odd++;
        if (!en) begin
          if (cap[base] !== 1'b1) b_off++;
        end else if (f == 13 || f == 15) begin
          e = (f == 13) ? ~err[0] : ~err[1];
          if (cap[base] !== e) b_e++;
        end else if (cap[base] !== MFP[5 - f / 2]) b_mf++;
      end
    end
    chk(b_pl == 0,  "R1 payload", b_pl, 0);
    chk(b_rq == 0,  "R1 request", b_rq, 0);
    chk(b_fas == 0, "R2 fas",     b_fas, 0);
    chk(b_odd == 0, "R3 odd ts0", b_odd, 0);
    chk(b_sy == 0,  "R9 sync",    b_sy, 0);
    if (en) begin
      chk(b_mf == 0, "R4 mf pattern", b_mf, 0);
      chk(b_e == 0,  "R5 e bits",     b_e, 0);
      chk(b_c == 0,  "R6 crc bits",   b_c, 0);
      if (fresh) chk(b_c0 == 0, "R7 zero crc", b_c0, 0);
    end else begin
      chk(b_off == 0, "R8 bit1 ones", b_off, 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    chk(1'b0, "watchdog", 0, 1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int w;
    crc_en_i = 1'b1; alarm_i = 1'b0; sa_i = 5'b01100; smf_err_i = 2'b00; payload_i = 1'b0;
    repeat (3) @(negedge clk_i);
    chk(tx_o == 1'b0 && mf_sync_o == 1'b0 && payload_req_o == 1'b0, "R10 reset state",
        {tx_o, mf_sync_o, payload_req_o}, 0);
    rst_ni = 1'b1;
    wait_sync(w);
    chk(w == 1, "R10 first bit is frame0 bit1", w, 1);
    chk(cap[0] == 1'b0, "R7 first C1", cap[0], 0);
    capture(4096);
    analyze(4096, 1'b1, 1'b0, 5'b01100, 2'b00, 1'b1);

    // table walk
    for (int v = 0; v < 5; v++) begin
      @(negedge clk_i);
      {crc_en_i, alarm_i, sa_i, smf_err_i} = VEC[v];
      wait_sync(w);
      capture(8192);
      analyze(8192, VEC[v][8], VEC[v][7], VEC[v][6:2], VEC[v][1:0], 1'b0);
    end

    // reset in mid-run
    crc_en_i = 1'b1;
    repeat (1000) begin @(negedge clk_i); step_pl(); end
    rst_ni = 1'b0;
    @(negedge clk_i);
    chk(tx_o == 1'b0 && mf_sync_o == 1'b0 && payload_req_o == 1'b0, "R10 mid reset",
        {tx_o, mf_sync_o, payload_req_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(mf_sync_o == 1'b1, "R10 restart at frame0", mf_sync_o, 1);
    chk(tx_o == 1'b0, "R7 C1 cleared by reset", tx_o, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule